// File: doc/BRIEF.md
# SD Command Sequencer with Response FIFO

This block issues a single SD/MMC command on the bidirectional CMD line and collects the card's reply. The host supplies a 6-bit command index, a 32-bit argument and a control word, then pulses `start`. The sequencer frames these into a 48-bit command token with a CRC7 and shifts it out most significant bit first. When asked, it first drives a run of idle-high clocks to wake the card. It then waits for the card's start bit, counting clocks against a programmable response timeout.

The reply is either 48 or 136 bits long, depending on a 2-bit response-type code. It is shifted in, checked against its CRC7 where the code asks for that, and left in a 16-bit-wide response FIFO. The host drains the FIFO one word per pop, most significant word first. Three sticky event bits, in a status word that is cleared by writing ones, report completion, a CRC mismatch and a response timeout.

The card clock is generated elsewhere. The block advances its line state only on cycles where `bit_tick` is high, so one tick is one card clock period.

Top module: `sdc_cmd_seq`

## Requirements
- R1: After an accepted start, `cmd_oe` is high and `cmd_out` presents the 48-bit token MSB first, one bit per tick. The token is: a 0 start bit, a 1 transmission bit, the 6-bit index, the 32-bit argument, a CRC7 (polynomial x^7+x^3+1, register cleared to zero) over the preceding 40 bits, and a 1 end bit.
- R2: When control bit 7 is set, 80 ticks with `cmd_oe` high and `cmd_out` high come before the token's start bit.
- R3: Control bits 1:0 select the response: 0 none, 1 48-bit with CRC check, 2 136-bit, 3 48-bit without CRC check. With code 0 the block goes idle at the end bit's tick, sets status bit 13 and leaves the FIFO empty.
- R4: A 48-bit response is offered as three FIFO words: bits 47..32, then 31..16, then 15..0.
- R5: A 136-bit response is offered as eight FIFO words holding bits 127..0, most significant word first.
- R6: Status bit 5 is set together with bit 13 only when the received CRC (bits 7..1) does not match the CRC7 of the covered bits. Code 1 covers bits 47..8 and code 2 covers bits 127..8. Code 3 never sets bit 5, and the end bit and the reserved bits 135..128 are never checked.
- R7: After the end bit, ticks that see CMD high are counted. When their number reaches the timeout value (at least 1), status bits 1 and 13 are set and the block goes idle. A start bit seen before that begins reception.
- R8: The 8-bit timeout register resets to 0xFF and is loaded by a write.
- R9: Status bits 13, 5 and 1 are cleared by writing a 1 to their position. Writing back the value just read clears every pending event, and zero bits leave events untouched.
- R10: A start pulse while the block is busy is ignored and does not disturb the command in flight.
- R11: On cycles without `bit_tick` nothing on the CMD line advances.
- R12: An accepted start empties the FIFO. A pop on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (taken only when idle) |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| cmd_ctrl | input | 8 | Bit 7 init run, bits 1:0 response type |
| tmo_we | input | 1 | Load the timeout register |
| tmo_wdata | input | 8 | Timeout value in ticks |
| stat_we | input | 1 | Write-one-to-clear strobe for status |
| stat_wdata | input | 16 | Bits to clear |
| status | output | 16 | Bit 13 done, bit 5 CRC error, bit 1 timeout |
| busy | output | 1 | A command is in flight |
| rsp_pop | input | 1 | Remove the head word of the FIFO |
| rsp_word | output | 16 | Head word of the FIFO |
| rsp_avail | output | 1 | FIFO holds at least one word |
| bit_tick | input | 1 | One card clock period elapses this cycle |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_in | input | 1 | CMD line sampled value |

## Verification
The bench goes after the CRC window edges. It corrupts a CRC bit under each response code and flips the unchecked end bit of a long reply. A design that checked the wrong span, or checked under code 3, would raise or miss bit 5. It sets the timeout one tick either side of the response's arrival and runs the 0xFF default to the exact expiring tick, which exposes an off-by-one in the wait counter. Gated ticks, an init run, a start pulse issued mid-token and a new command over an unread FIFO catch a sequencer that advances without a tick, restarts while busy or serves stale words.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_SEND,
        ST_WAIT,
        ST_RESP
    } seq_state_e;

    typedef enum logic [1:0] {
        RT_NONE      = 2'd0,
        RT_SHORT_CRC = 2'd1,
        RT_LONG      = 2'd2,
        RT_SHORT_RAW = 2'd3
    } rsp_kind_e;

    typedef struct packed {
        logic done;
        logic crc_err;
        logic timeout;
    } seq_evt_t;

    localparam int STAT_W        = 16;
    localparam int STAT_DONE_BIT = 13;
    localparam int STAT_CRC_BIT  = 5;
    localparam int STAT_TMO_BIT  = 1;
    localparam int TOKEN_BITS    = 48;
    localparam int CRC_W         = 7;

    // one serial step of the x^7 + x^3 + 1 generator
    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic d);
        logic fb;
        fb = d ^ c[6];
        return {c[5:3], c[2] ^ fb, c[1:0], fb};
    endfunction

    function automatic logic [TOKEN_BITS-1:0] build_token(input logic [5:0] idx,
                                                          input logic [31:0] arg);
        logic [39:0]      head;
        logic [CRC_W-1:0] c;
        head = {2'b01, idx, arg};
        c    = '0;
        for (int i = 39; i >= 0; i--) c = crc7_step(c, head[i]);
        return {head, c, 1'b1};
    endfunction

endpackage

// File: rtl/sdc_crc7_acc.sv
module sdc_crc7_acc
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) crc <= '0;
        else if (en)    crc <= crc7_step(crc, din);
    end
endmodule

// File: rtl/sdc_rsp_fifo.sv
module sdc_rsp_fifo #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    load,
    input  logic [$clog2(DEPTH+1)-1:0] load_cnt,
    input  logic [WORD_W*DEPTH-1:0] load_words,
    input  logic                    pop,
    output logic [WORD_W-1:0]       word,
    output logic                    avail
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_q;
    logic [CNT_W-1:0]  cnt_q;

    assign avail = (cnt_q != '0);
    assign word  = mem[rd_q];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rd_q  <= '0;
            cnt_q <= load_cnt;
        end else if (pop && avail) begin
            rd_q  <= rd_q + 1'b1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)       mem[k] <= '0;
            else if (load) mem[k] <= load_words[k*WORD_W +: WORD_W];
        end
    end

    assert_fifo_bound_R12: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));
    assert_pop_empty_R12: assert property (@(posedge clk) disable iff (rst)
        (!avail && pop && !load && !clr) |=> !avail);
endmodule

// File: rtl/sdc_status_w1c.sv
module sdc_status_w1c
    import sdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  seq_evt_t          evt,
    input  logic              we,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] status
);
    seq_evt_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q.done    <= evt.done    | (flags_q.done    & ~(we & wdata[STAT_DONE_BIT]));
            flags_q.crc_err <= evt.crc_err | (flags_q.crc_err & ~(we & wdata[STAT_CRC_BIT]));
            flags_q.timeout <= evt.timeout | (flags_q.timeout & ~(we & wdata[STAT_TMO_BIT]));
        end
    end

    always_comb begin
        status                = '0;
        status[STAT_DONE_BIT] = flags_q.done;
        status[STAT_CRC_BIT]  = flags_q.crc_err;
        status[STAT_TMO_BIT]  = flags_q.timeout;
    end

    assert_w1c_done_R9: assert property (@(posedge clk) disable iff (rst)
        (we && wdata[STAT_DONE_BIT] && !evt.done) |=> !status[STAT_DONE_BIT]);
    assert_w1c_crc_R9: assert property (@(posedge clk) disable iff (rst)
        (we && wdata[STAT_CRC_BIT] && !evt.crc_err) |=> !status[STAT_CRC_BIT]);
endmodule

// File: rtl/sdc_cmd_seq.sv
module sdc_cmd_seq
    import sdc_pkg::*;
#(
    parameter int INIT_CLKS = 80,
    parameter int WORD_W    = 16,
    parameter int LONG_BITS = 136,
    parameter int TMO_W     = 8,
    parameter logic [7:0] TMO_RESET = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [5:0]        cmd_index,
    input  logic [31:0]       cmd_arg,
    input  logic [7:0]        cmd_ctrl,
    input  logic              tmo_we,
    input  logic [TMO_W-1:0]  tmo_wdata,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] status,
    output logic              busy,
    input  logic              rsp_pop,
    output logic [WORD_W-1:0] rsp_word,
    output logic              rsp_avail,
    input  logic              bit_tick,
    output logic              cmd_out,
    output logic              cmd_oe,
    input  logic              cmd_in
);
    localparam int SHORT_BITS  = TOKEN_BITS;
    localparam int LONG_PAY    = LONG_BITS - 8;
    localparam int TAIL_BITS   = CRC_W + 1;
    localparam int RSP_WORDS   = LONG_PAY / WORD_W;
    localparam int SHORT_WORDS = SHORT_BITS / WORD_W;
    localparam int CNT_W       = $clog2(LONG_BITS);
    localparam int ICNT_W      = $clog2(INIT_CLKS + 1);
    localparam int LCNT_W      = $clog2(RSP_WORDS + 1);

    seq_state_e            state_q;
    rsp_kind_e             rtype_q;
    logic [CNT_W-1:0]      bcnt_q;
    logic [ICNT_W-1:0]     icnt_q;
    logic [TMO_W-1:0]      wcnt_q;
    logic [TMO_W-1:0]      tmo_q;
    logic [TOKEN_BITS-1:0] tx_q;
    logic [LONG_BITS-1:0]  rx_q;
    logic [LONG_BITS-1:0]  rx_next;
    logic [CRC_W-1:0]      crc_q;
    logic                  take;
    logic                  is_long;
    logic                  last_rx;
    logic                  tmo_hit;
    logic [CNT_W-1:0]      rx_idx;
    logic                  in_win;
    logic                  crc_en;
    seq_evt_t              evt;
    logic [WORD_W*RSP_WORDS-1:0] load_words;

    assign take    = start && (state_q == ST_IDLE);
    assign busy    = (state_q != ST_IDLE);
    assign is_long = (rtype_q == RT_LONG);
    assign rx_next = {rx_q[LONG_BITS-2:0], cmd_in};
    assign cmd_oe  = (state_q == ST_INIT) || (state_q == ST_SEND);
    assign cmd_out = (state_q == ST_SEND) ? tx_q[TOKEN_BITS-1] : 1'b1;

    assign last_rx = bit_tick && (state_q == ST_RESP) &&
                     (bcnt_q == (is_long ? CNT_W'(LONG_BITS-1) : CNT_W'(SHORT_BITS-1)));
    assign tmo_hit = bit_tick && (state_q == ST_WAIT) && cmd_in &&
                     ({1'b0, wcnt_q} + 1'b1 >= {1'b0, tmo_q});

    // position of the incoming bit within the frame, counted from its start bit
    assign rx_idx = (state_q == ST_WAIT) ? '0 : bcnt_q;
    assign in_win = is_long ? (rx_idx >= CNT_W'(LONG_BITS-LONG_PAY) && rx_idx < CNT_W'(LONG_BITS-TAIL_BITS))
                            : (rx_idx < CNT_W'(SHORT_BITS-TAIL_BITS));
    assign crc_en = bit_tick && in_win &&
                    (((state_q == ST_WAIT) && !cmd_in) || (state_q == ST_RESP));

    always_comb begin
        evt.done    = tmo_hit || last_rx ||
                      (bit_tick && (state_q == ST_SEND) &&
                       bcnt_q == CNT_W'(TOKEN_BITS-1) && rtype_q == RT_NONE);
        evt.timeout = tmo_hit;
        evt.crc_err = last_rx && (rtype_q == RT_SHORT_CRC || rtype_q == RT_LONG) &&
                      (crc_q != rx_next[TAIL_BITS-1:1]);
    end

    for (genvar k = 0; k < RSP_WORDS; k++) begin : g_word
        if (k < SHORT_WORDS) begin : g_both
            assign load_words[k*WORD_W +: WORD_W] = is_long ?
                rx_next[LONG_PAY-1-k*WORD_W -: WORD_W] : rx_next[SHORT_BITS-1-k*WORD_W -: WORD_W];
        end else begin : g_long
            assign load_words[k*WORD_W +: WORD_W] = is_long ?
                rx_next[LONG_PAY-1-k*WORD_W -: WORD_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            rtype_q <= RT_NONE;
            bcnt_q  <= '0;
            icnt_q  <= '0;
            wcnt_q  <= '0;
            tmo_q   <= TMO_RESET;
            tx_q    <= '0;
            rx_q    <= '0;
        end else begin
            if (tmo_we) tmo_q <= tmo_wdata;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    tx_q    <= build_token(cmd_index, cmd_arg);
                    rtype_q <= rsp_kind_e'(cmd_ctrl[1:0]);
                    bcnt_q  <= '0;
                    icnt_q  <= '0;
                    wcnt_q  <= '0;
                    state_q <= cmd_ctrl[7] ? ST_INIT : ST_SEND;
                end
                ST_INIT: if (bit_tick) begin
                    if (icnt_q == ICNT_W'(INIT_CLKS-1)) state_q <= ST_SEND;
                    else                                icnt_q  <= icnt_q + 1'b1;
                end
                ST_SEND: if (bit_tick) begin
                    tx_q <= {tx_q[TOKEN_BITS-2:0], 1'b0};
                    if (bcnt_q == CNT_W'(TOKEN_BITS-1)) begin
                        bcnt_q  <= '0;
                        state_q <= (rtype_q == RT_NONE) ? ST_IDLE : ST_WAIT;
                    end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                end
                ST_WAIT: if (bit_tick) begin
                    if (!cmd_in) begin
                        rx_q    <= rx_next;
                        bcnt_q  <= CNT_W'(1);
                        state_q <= ST_RESP;
                    end else if (tmo_hit) begin
                        state_q <= ST_IDLE;
                    end else begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end
                end
                ST_RESP: if (bit_tick) begin
                    rx_q <= rx_next;
                    if (last_rx) begin
                        bcnt_q  <= '0;
                        state_q <= ST_IDLE;
                    end else begin
                        bcnt_q <= bcnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    sdc_crc7_acc u_crc (
        .clk (clk),
        .rst (rst),
        .clr (take),
        .en  (crc_en),
        .din (cmd_in),
        .crc (crc_q)
    );

    sdc_rsp_fifo #(.WORD_W(WORD_W), .DEPTH(RSP_WORDS)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .clr        (take),
        .load       (last_rx),
        .load_cnt   (is_long ? LCNT_W'(RSP_WORDS) : LCNT_W'(SHORT_WORDS)),
        .load_words (load_words),
        .pop        (rsp_pop),
        .word       (rsp_word),
        .avail      (rsp_avail)
    );

    sdc_status_w1c u_stat (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt),
        .we     (stat_we),
        .wdata  (stat_wdata),
        .status (status)
    );

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(rtype_q));
    assert_oe_end_bit_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_oe) |-> $past(cmd_out));
    assert_crc_type_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(status[STAT_CRC_BIT]) |-> (rtype_q == RT_SHORT_CRC || rtype_q == RT_LONG));
    assert_tmo_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(status[STAT_TMO_BIT]) |-> status[STAT_DONE_BIT]);
endmodule

// File: tb/tb_sdc_cmd_seq.sv
module tb_sdc_cmd_seq;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, start, tmo_we, stat_we, rsp_pop, bit_tick, cmd_in;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic [7:0]  cmd_ctrl, tmo_wdata;
    logic [15:0] stat_wdata, status, rsp_word;
    logic        busy, rsp_avail, cmd_out, cmd_oe;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    sdc_cmd_seq dut (
        .clk(clk), .rst(rst), .start(start), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .cmd_ctrl(cmd_ctrl), .tmo_we(tmo_we), .tmo_wdata(tmo_wdata), .stat_we(stat_we),
        .stat_wdata(stat_wdata), .status(status), .busy(busy), .rsp_pop(rsp_pop),
        .rsp_word(rsp_word), .rsp_avail(rsp_avail), .bit_tick(bit_tick),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in)
    );

    task automatic chk(input string tag, input logic [135:0] act, input logic [135:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] ref_crc(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c = '0;
        for (int i = hi; i >= lo; i--) begin
            logic fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [47:0] mk_token(input logic [5:0] idx, input logic [31:0] arg);
        logic [135:0] t = '0;
        t[47:8] = {2'b01, idx, arg};
        t[7:1]  = ref_crc(t, 47, 8);
        t[0]    = 1'b1;
        return t[47:0];
    endfunction

    function automatic logic [135:0] mk_short(input logic [5:0] idx, input logic [31:0] card);
        logic [135:0] f = '0;
        f[47:8] = {2'b00, idx, card};
        f[7:1]  = ref_crc(f, 47, 8);
        f[0]    = 1'b1;
        return f;
    endfunction

    function automatic logic [135:0] mk_long(input logic [119:0] body);
        logic [135:0] f = '0;
        f[135:128] = 8'h3F;
        f[127:8]   = body;
        f[7:1]     = ref_crc(f, 127, 8);
        f[0]       = 1'b1;
        return f;
    endfunction

    // starts a command and checks the CMD line bit by bit; returns at the negedge after the last tick
    task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg, input logic [7:0] ctrl,
                            input bit gate, input bit poke);
        logic [47:0] tok = mk_token(idx, arg);
        int pre   = ctrl[7] ? 80 : 0;
        int total = pre + 48;
        int used  = 0;
        int cyc   = 0;
        cmd_index = idx; cmd_arg = arg; cmd_ctrl = ctrl; start = 1'b1; bit_tick = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy after start", busy, 1);
        chk("R12 fifo emptied by start", rsp_avail, 0);
        while (used < total) begin
            if (used < pre) begin
                chk("R2 init oe", cmd_oe, 1);
                chk("R2 init level", cmd_out, 1);
            end else begin
                chk("R1 token oe", cmd_oe, 1);
                chk(gate ? "R11 gated token bit" : "R1 token bit", cmd_out, tok[47 - (used - pre)]);
            end
            bit_tick = gate ? cyc[0] : 1'b1;
            if (poke && used == 10) begin
                start = 1'b1; cmd_index = ~idx; cmd_ctrl = 8'h82;
            end else begin
                start = 1'b0;
            end
            if (bit_tick) used++;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0; bit_tick = 1'b1;
    endtask

    task automatic respond(input logic [135:0] f, input int len, input int gap);
        for (int g = 0; g < gap; g++) begin cmd_in = 1'b1; @(negedge clk); end
        for (int i = 0; i < len; i++) begin cmd_in = f[len-1-i]; @(negedge clk); end
        cmd_in = 1'b1;
    endtask

    task automatic pop_all(input logic [135:0] f, input bit long_rsp);
        int n = long_rsp ? 8 : 3;
        for (int k = 0; k < n; k++) begin
            logic [15:0] exp = long_rsp ? f[127-16*k -: 16] : f[47-16*k -: 16];
            chk("R12 word available", rsp_avail, 1);
            chk(long_rsp ? "R5 long word" : "R4 short word", rsp_word, exp);
            rsp_pop = 1'b1;
            @(negedge clk);
            rsp_pop = 1'b0;
        end
        chk("R12 fifo drained", rsp_avail, 0);
        rsp_pop = 1'b1;
        @(negedge clk);
        rsp_pop = 1'b0;
        chk("R12 pop on empty", rsp_avail, 0);
    endtask

    task automatic wr_status(input logic [15:0] v);
        stat_we = 1'b1; stat_wdata = v;
        @(negedge clk);
        stat_we = 1'b0; stat_wdata = '0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [135:0] f;
        rst = 1'b1; start = 0; tmo_we = 0; stat_we = 0; rsp_pop = 0; bit_tick = 1; cmd_in = 1;
        cmd_index = '0; cmd_arg = '0; cmd_ctrl = '0; tmo_wdata = '0; stat_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("reset status", status, 0);
        chk("reset busy", busy, 0);
        chk("reset oe", cmd_oe, 0);
        chk("reset fifo", rsp_avail, 0);

        // no response, no init
        send_cmd(6'd0, 32'h0, 8'h00, 0, 0);
        chk("R3 none done", status, 16'h2000);
        chk("R3 none idle", busy, 0);
        chk("R3 none fifo", rsp_avail, 0);
        wr_status(16'h2000);
        chk("R9 writeback clear", status, 0);

        // init run then token
        send_cmd(6'd8, 32'h0000_01AA, 8'h80, 0, 0);
        chk("R2 done after init cmd", status, 16'h2000);
        wr_status(status);

        // 48-bit with CRC, good
        send_cmd(6'd17, 32'h0000_1234, 8'h01, 0, 0);
        f = mk_short(6'd17, 32'h0000_0900);
        respond(f, 48, 3);
        chk("R6 short good crc", status, 16'h2000);
        chk("R3 idle after short", busy, 0);
        pop_all(f, 0);
        wr_status(16'h2000);

        // 48-bit with CRC, corrupted CRC
        send_cmd(6'd13, 32'hDEAD_BEEF, 8'h01, 0, 0);
        f = mk_short(6'd13, 32'hCAFE_F00D);
        f[3] = ~f[3];
        respond(f, 48, 0);
        chk("R6 short bad crc", status, 16'h2020);
        pop_all(f, 0);
        wr_status(16'h0020);
        chk("R9 partial clear", status, 16'h2000);
        wr_status(16'h2000);
        chk("R9 all clear", status, 0);

        // 48-bit without CRC check, corrupted CRC, left unread
        send_cmd(6'd41, 32'h00FF_8000, 8'h03, 0, 0);
        f = mk_short(6'd41, 32'h80FF_8000);
        f[6] = ~f[6];
        respond(f, 48, 7);
        chk("R6 raw type no crc err", status, 16'h2000);
        chk("R4 raw words present", rsp_avail, 1);
        wr_status(16'h2000);

        // 136-bit good (also proves the unread FIFO was emptied by start)
        send_cmd(6'd2, 32'h0, 8'h02, 0, 0);
        f = mk_long(120'h1B_5344_5343_3136_4780_1234_5678_00C9);
        respond(f, 136, 2);
        chk("R6 long good crc", status, 16'h2000);
        pop_all(f, 1);
        wr_status(16'h2000);

        // 136-bit bad CRC
        send_cmd(6'd9, 32'h1234_0000, 8'h02, 0, 0);
        f = mk_long(120'hA5A5_0F0F_1234_8765_4321_FEDC_BA98_76);
        f[1] = ~f[1];
        respond(f, 136, 0);
        chk("R6 long bad crc", status, 16'h2020);
        pop_all(f, 1);
        wr_status(16'h2020);

        // 136-bit with end bit flipped: not checked
        send_cmd(6'd10, 32'h5678_0000, 8'h02, 0, 0);
        f = mk_long(120'h0123_4567_89AB_CDEF_0011_2233_4455_66);
        f[0] = 1'b0;
        respond(f, 136, 1);
        chk("R6 long end bit unchecked", status, 16'h2000);
        pop_all(f, 1);
        wr_status(16'h2000);

        // default timeout 0xFF
        send_cmd(6'd55, 32'h0, 8'h01, 0, 0);
        cmd_in = 1'b1;
        repeat (254) @(negedge clk);
        chk("R8 no timeout at 254", status[1], 0);
        chk("R8 still waiting", busy, 1);
        @(negedge clk);
        chk("R8 timeout at 255", status, 16'h2002);
        chk("R7 idle after timeout", busy, 0);
        wr_status(status);
        chk("R9 writeback clears timeout", status, 0);

        // programmed timeout 5: response after 4 idle ticks is accepted
        tmo_we = 1'b1; tmo_wdata = 8'd5;
        @(negedge clk);
        tmo_we = 1'b0;
        send_cmd(6'd7, 32'h0001_0000, 8'h01, 0, 0);
        f = mk_short(6'd7, 32'h0000_0700);
        respond(f, 48, 4);
        chk("R7 response just in time", status, 16'h2000);
        pop_all(f, 0);
        wr_status(16'h2000);

        send_cmd(6'd7, 32'h0001_0000, 8'h03, 0, 0);
        cmd_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 no timeout at 4", status, 0);
        @(negedge clk);
        chk("R7 timeout at 5", status, 16'h2002);
        chk("R7 fifo empty on timeout", rsp_avail, 0);
        wr_status(16'h2002);

        // gated ticks
        send_cmd(6'd24, 32'h8000_0001, 8'h00, 1, 0);
        chk("R11 gated done", status, 16'h2000);
        wr_status(16'h2000);

        // start pulse while busy
        send_cmd(6'd12, 32'h0F0F_F0F0, 8'h00, 0, 1);
        chk("R10 one completion", status, 16'h2000);
        chk("R10 idle", busy, 0);
        @(negedge clk);
        chk("R10 no second command", cmd_oe, 0);
        chk("R10 still idle", busy, 0);
        wr_status(16'h2000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule